// File: doc/BRIEF.md
# Prioritised Interrupt Claim Arbiter

This block is the decision core of a platform interrupt controller that serves several interrupt contexts. A context is one hart running in one privilege mode. The block samples level-sensitive interrupt lines into per-source pending bits and tracks which sources are in service in a per-source claimed vector. It holds a priority for each source, and an enable vector and a threshold for each context. For every context it searches for the best eligible source and raises that hart's machine-level or supervisor-level external interrupt request.

A register front end, which is not part of this block, forwards configuration writes as one-cycle strobes. It also turns claim reads and complete writes into strobes that carry a context index or a source ID. During a claim, `claim_id_o` gives the winner for the addressed context. The winner leaves the pending set and enters the claimed set at the same clock edge. It stays out of every selection until a complete names its ID.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source can be selected for a context only while it is pending, not claimed, and its bit in that context's enable vector is 1.
- R2: The search begins with the context threshold as the bar. A source wins only when its priority is strictly greater than the best so far, so among equal priorities the lowest source ID is selected. When nothing beats the threshold the selected ID is 0.
- R3: A context's interrupt request is a register that equals (selected ID != 0) as evaluated in the previous cycle. It follows any change of pending, claimed, enable, priority or threshold state by one clock.
- R4: During a claim strobe, `claim_id_o` shows the selected ID of `claim_ctx_i`. If that ID is nonzero, at the same edge its pending bit is cleared and its claimed bit is set. The source then stays unselectable for all contexts, even while its line stays high, until it is completed.
- R5: A complete strobe clears the claimed bit of `done_id_i`. A complete whose ID is NUM_SRC or larger changes nothing.
- R6: Each pending bit is the registered level of its line. A rise or fall is visible in `claim_id_o` one cycle later.
- R7: A context with mode code 2'b11 drives `mach_irq_o[hart]` and a context with mode code 2'b01 drives `sup_irq_o[hart]`. Codes 2'b00 and 2'b10 drive no output. The mode code comes from CTX_MODE bits [2c+1:2c] and the hart from CTX_HART bits [4c+3:4c]. The default mapping is: context 0 is hart 0 with mode 11, context 1 is hart 0 with mode 01, context 2 is hart 1 with mode 11, and context 3 is hart 1 with mode 00.
- R8: Synchronous active-low reset clears all priorities, thresholds, enables, pending and claimed bits, and all interrupt outputs.
- R9: Source ID 0 is reserved. Its line and its enable bits are ignored, and it is never pending or selected.
- R10: A threshold write with a value above MAX_PRIO (default 5) is ignored and the old threshold is kept.
- R11: A claim strobe when nothing is selectable returns 0 and leaves the claimed state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line_i | input | NUM_SRC | Level interrupt lines, bit n is source n |
| prio_we_i | input | 1 | Source priority write strobe |
| prio_id_i | input | ID_W | Source ID to write |
| prio_val_i | input | PRIO_W | New priority |
| thr_we_i | input | 1 | Context threshold write strobe |
| thr_ctx_i | input | CTX_W | Context to write |
| thr_val_i | input | PRIO_W | New threshold |
| en_we_i | input | 1 | Context enable vector write strobe |
| en_ctx_i | input | CTX_W | Context to write |
| en_val_i | input | NUM_SRC | New enable vector, bit n enables source n |
| claim_i | input | 1 | Claim strobe |
| claim_ctx_i | input | CTX_W | Context whose winner is shown and claimed |
| claim_id_o | output | ID_W | Selected ID for claim_ctx_i (0 = none) |
| done_i | input | 1 | Complete strobe |
| done_id_i | input | ID_W | Source ID being completed |
| mach_irq_o | output | NUM_HART | Machine external interrupt request per hart |
| sup_irq_o | output | NUM_HART | Supervisor external interrupt request per hart |

## Verification
The selection is driven from a table. Each row sets a line pattern, an enable vector and a threshold against a fixed priority ramp. The rows separate a strict compare from a greater-or-equal compare, a tie won by the lowest ID from one won by the highest, a higher priority beating a lower ID, masking by the enable vector, and the reserved source 0. Directed sequences then measure the one-cycle lags from line to pending to output. They also hold a line high across a claim to show the source stays out of selection, try an out-of-range complete against a real one, route contexts to the machine, supervisor and unrouted outputs, and try an oversized threshold.

// File: rtl/irq_arb_pkg.sv
// Shared types for the interrupt claim arbiter.
// Assumes context privilege modes are coded in two bits; only machine and
// supervisor codes are routed to hart request lines.
package irq_arb_pkg;

    typedef enum logic [1:0] {
        CTX_USER    = 2'b00,
        CTX_SUPER   = 2'b01,
        CTX_HYPER   = 2'b10,
        CTX_MACHINE = 2'b11
    } ctx_mode_e;

    // Width of each hart index field in the context-to-hart map parameter.
    localparam int HART_IDX_W = 4;

endpackage

// File: rtl/irq_src_gateway.sv
// Per-source pending and claimed state.
// Pending registers the line level every cycle, except that a claim of the
// same source clears it for that edge. Claimed is set by a claim and cleared
// by an in-range complete; a claim of a source wins over its complete.
// Assumes claim_id_i is always below NUM_SRC (it comes from the selectors).
module irq_src_gateway #(
    parameter int NUM_SRC = 12,
    parameter int ID_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic               claim_set_i,
    input  logic [ID_W-1:0]    claim_id_i,
    input  logic               done_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] claimed_o
);

    logic done_ok;

    // Complete is honoured only for IDs inside the source range.
    assign done_ok = done_i && ({1'b0, done_id_i} < (ID_W+1)'(NUM_SRC));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == 0) begin : g_rsvd
            // Source 0 is reserved and holds no state.
            assign pending_o[s] = 1'b0;
            assign claimed_o[s] = 1'b0;
        end else begin : g_live
            logic hit_claim;
            logic hit_done;
            logic pend_q;
            logic clm_q;

            assign hit_claim = claim_set_i && (claim_id_i == ID_W'(s));
            assign hit_done  = done_ok && (done_id_i == ID_W'(s));

            // Pending follows the line level, dropped for a claim edge.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q <= 1'b0;
                else        pend_q <= line_i[s] && !hit_claim;
            end

            // Claimed is set by a claim and released by a complete.
            always_ff @(posedge clk) begin
                if (!rst_n)         clm_q <= 1'b0;
                else if (hit_claim) clm_q <= 1'b1;
                else if (hit_done)  clm_q <= 1'b0;
            end

            assign pending_o[s] = pend_q;
            assign claimed_o[s] = clm_q;
        end
    end

    // R4: a claimed source is captured and leaves the pending set.
    p_claim_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        claim_set_i |=> claimed_o[$past(claim_id_i)] && !pending_o[$past(claim_id_i)]);

    // R5: an out-of-range complete leaves the claimed set untouched.
    p_oob_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ({1'b0, done_id_i} >= (ID_W+1)'(NUM_SRC)) && !claim_set_i)
        |=> $stable(claimed_o));

    // R5: an in-range complete releases its source.
    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ({1'b0, done_id_i} < (ID_W+1)'(NUM_SRC)) && !claim_set_i)
        |=> !claimed_o[$past(done_id_i)]);

endmodule

// File: rtl/irq_cfg_store.sv
// Configuration state: source priorities, context thresholds and context
// enable vectors, each written through a one-cycle strobe.
// Assumes write strobes are single-cycle and indices come from a decoded
// front end; out-of-range indices match no entry and are dropped.
module irq_cfg_store #(
    parameter int NUM_SRC  = 12,
    parameter int NUM_CTX  = 4,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5,
    parameter int ID_W     = 4,
    parameter int CTX_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             prio_we_i,
    input  logic [ID_W-1:0]                  prio_id_i,
    input  logic [PRIO_W-1:0]                prio_val_i,
    input  logic                             thr_we_i,
    input  logic [CTX_W-1:0]                 thr_ctx_i,
    input  logic [PRIO_W-1:0]                thr_val_i,
    input  logic                             en_we_i,
    input  logic [CTX_W-1:0]                 en_ctx_i,
    input  logic [NUM_SRC-1:0]               en_val_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]   thr_o,
    output logic [NUM_CTX-1:0][NUM_SRC-1:0]  en_o
);

    logic thr_in_range;

    // Threshold values above the top priority are refused.
    assign thr_in_range = ({1'b0, thr_val_i} <= (PRIO_W+1)'(MAX_PRIO));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
        if (s == 0) begin : g_rsvd
            assign prio_o[s] = '0;
        end else begin : g_reg
            logic [PRIO_W-1:0] prio_q;
            // Holds the priority of one source.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_q <= '0;
                else if (prio_we_i && prio_id_i == ID_W'(s))
                    prio_q <= prio_val_i;
            end
            assign prio_o[s] = prio_q;
        end
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [PRIO_W-1:0]  thr_q;
        logic [NUM_SRC-1:0] en_q;

        // Holds the context threshold; oversized values are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q <= '0;
            else if (thr_we_i && thr_ctx_i == CTX_W'(c) && thr_in_range)
                thr_q <= thr_val_i;
        end

        // Holds the context enable vector with the reserved bit forced low.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q <= '0;
            else if (en_we_i && en_ctx_i == CTX_W'(c))
                en_q <= en_val_i & ~NUM_SRC'(1);
        end

        assign thr_o[c] = thr_q;
        assign en_o[c]  = en_q;

        // R10: a stored threshold never exceeds the top priority.
        p_thr_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, thr_o[c]} <= (PRIO_W+1)'(MAX_PRIO));
    end

endmodule

// File: rtl/irq_ctx_pick.sv
// Winner search for one context: walks the sources upward from ID 1,
// keeping the threshold as the starting bar and replacing the winner only on
// a strictly greater priority, so the lowest ID wins a tie.
// Assumes source 0 carries no pending state; it is skipped regardless.
module irq_ctx_pick #(
    parameter int NUM_SRC = 12,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             claimed_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                pick_id_o
);

    logic [NUM_SRC-1:0] elig;
    logic [PRIO_W-1:0]  bar;

    // Eligible sources are pending, unclaimed and enabled here.
    assign elig = pend_i & ~claimed_i & en_i;

    // Linear strict-greater scan from the lowest ID.
    always_comb begin
        bar       = thr_i;
        pick_id_o = '0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (elig[s] && (prio_i[s] > bar)) begin
                bar       = prio_i[s];
                pick_id_o = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/irq_claim_arbiter.sv
// Top of the interrupt claim arbiter. Ties together source state, the
// configuration store and one winner search per context, registers each
// context's request and routes it to its hart's machine or supervisor line.
// Assumes a front end supplies one-cycle strobes; claim_id_o is combinational
// so it can be returned in the same cycle as the claim strobe.
module irq_claim_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 12,
    parameter int NUM_CTX  = 4,
    parameter int NUM_HART = 2,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5,
    parameter logic [2*NUM_CTX-1:0]          CTX_MODE = 8'b00_11_01_11,
    parameter logic [HART_IDX_W*NUM_CTX-1:0] CTX_HART = 16'h1100,
    localparam int ID_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_line_i,
    input  logic                prio_we_i,
    input  logic [ID_W-1:0]     prio_id_i,
    input  logic [PRIO_W-1:0]   prio_val_i,
    input  logic                thr_we_i,
    input  logic [CTX_W-1:0]    thr_ctx_i,
    input  logic [PRIO_W-1:0]   thr_val_i,
    input  logic                en_we_i,
    input  logic [CTX_W-1:0]    en_ctx_i,
    input  logic [NUM_SRC-1:0]  en_val_i,
    input  logic                claim_i,
    input  logic [CTX_W-1:0]    claim_ctx_i,
    output logic [ID_W-1:0]     claim_id_o,
    input  logic                done_i,
    input  logic [ID_W-1:0]     done_id_i,
    output logic [NUM_HART-1:0] mach_irq_o,
    output logic [NUM_HART-1:0] sup_irq_o
);

    logic [NUM_SRC-1:0]              pend;
    logic [NUM_SRC-1:0]              claimed;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
    logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
    logic [NUM_CTX-1:0][ID_W-1:0]    pick_id;
    logic [NUM_CTX-1:0]              pick_nz;
    logic [NUM_CTX-1:0]              ctx_irq_q;
    logic                            claim_set;

    irq_src_gateway #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_gateway (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (irq_line_i),
        .claim_set_i (claim_set),
        .claim_id_i  (claim_id_o),
        .done_i      (done_i),
        .done_id_i   (done_id_i),
        .pending_o   (pend),
        .claimed_o   (claimed)
    );

    irq_cfg_store #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CTX  (NUM_CTX),
        .PRIO_W   (PRIO_W),
        .MAX_PRIO (MAX_PRIO),
        .ID_W     (ID_W),
        .CTX_W    (CTX_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we_i  (prio_we_i),
        .prio_id_i  (prio_id_i),
        .prio_val_i (prio_val_i),
        .thr_we_i   (thr_we_i),
        .thr_ctx_i  (thr_ctx_i),
        .thr_val_i  (thr_val_i),
        .en_we_i    (en_we_i),
        .en_ctx_i   (en_ctx_i),
        .en_val_i   (en_val_i),
        .prio_o     (prio),
        .thr_o      (thr),
        .en_o       (en)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_pick
        irq_ctx_pick #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_pick (
            .pend_i    (pend),
            .claimed_i (claimed),
            .en_i      (en[c]),
            .prio_i    (prio),
            .thr_i     (thr[c]),
            .pick_id_o (pick_id[c])
        );

        assign pick_nz[c] = (pick_id[c] != '0);

        // R1: a selected source is pending, unclaimed and enabled here.
        p_pick_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
            pick_nz[c] |-> (pend[pick_id[c]] && !claimed[pick_id[c]] && en[c][pick_id[c]]));

        // R2: a selected source is strictly above the context threshold.
        p_pick_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pick_nz[c] |-> (prio[pick_id[c]] > thr[c]));
    end

    // Claim response: the winner of the addressed context.
    always_comb begin
        if ({1'b0, claim_ctx_i} < (CTX_W+1)'(NUM_CTX))
            claim_id_o = pick_id[claim_ctx_i];
        else
            claim_id_o = '0;
    end

    assign claim_set = claim_i && (claim_id_o != '0);

    // Registers each context's request one cycle behind its selection.
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_irq_q <= '0;
        else        ctx_irq_q <= pick_nz;
    end

    // Routes context requests to hart lines by mode; other modes are dropped.
    always_comb begin
        mach_irq_o = '0;
        sup_irq_o  = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            for (int h = 0; h < NUM_HART; h++) begin
                if (int'(CTX_HART[HART_IDX_W*c +: HART_IDX_W]) == h) begin
                    if (CTX_MODE[2*c +: 2] == CTX_MACHINE)
                        mach_irq_o[h] = mach_irq_o[h] | ctx_irq_q[c];
                    else if (CTX_MODE[2*c +: 2] == CTX_SUPER)
                        sup_irq_o[h] = sup_irq_o[h] | ctx_irq_q[c];
                end
            end
        end
    end

    // R3: each request equals the previous cycle's selection result.
    p_irq_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctx_irq_q == $past(pick_nz)));

    // R8: reset leaves every request low.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (ctx_irq_q == '0));

    // R11: a claim with no winner does not touch the claimed set.
    p_empty_claim_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && claim_id_o == '0 && !done_i) |=> $stable(claimed));

endmodule

// File: tb/tb_irq_claim_arbiter.sv
module tb_irq_claim_arbiter;

    localparam int NS = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   lines = '0;
    logic            prio_we = 1'b0;
    logic [3:0]      prio_id = '0;
    logic [2:0]      prio_val = '0;
    logic            thr_we = 1'b0;
    logic [1:0]      thr_ctx = '0;
    logic [2:0]      thr_val = '0;
    logic            en_we = 1'b0;
    logic [1:0]      en_ctx = '0;
    logic [NS-1:0]   en_val = '0;
    logic            claim = 1'b0;
    logic [1:0]      claim_ctx = '0;
    logic [3:0]      claim_id;
    logic            done = 1'b0;
    logic [3:0]      done_id = '0;
    logic [1:0]      mach_irq;
    logic [1:0]      sup_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_claim_arbiter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_line_i  (lines),
        .prio_we_i   (prio_we),
        .prio_id_i   (prio_id),
        .prio_val_i  (prio_val),
        .thr_we_i    (thr_we),
        .thr_ctx_i   (thr_ctx),
        .thr_val_i   (thr_val),
        .en_we_i     (en_we),
        .en_ctx_i    (en_ctx),
        .en_val_i    (en_val),
        .claim_i     (claim),
        .claim_ctx_i (claim_ctx),
        .claim_id_o  (claim_id),
        .done_i      (done),
        .done_id_i   (done_id),
        .mach_irq_o  (mach_irq),
        .sup_irq_o   (sup_irq)
    );

    // Vector: {lines[11:0], ctx0 enable[11:0], ctx0 threshold[3:0], expected id[3:0]}
    // Priorities: source n has priority (n % 4) + 1.
    localparam logic [31:0] VEC [0:8] = '{
        {12'h006, 12'hFFE, 4'd0, 4'd2},   // R2: 2 (prio 3) over 1 (prio 2)
        {12'h088, 12'hFFE, 4'd0, 4'd3},   // R2: tie at prio 4, lowest ID
        {12'h088, 12'hFFE, 4'd4, 4'd0},   // R2: equal to threshold loses
        {12'h088, 12'hFFE, 4'd3, 4'd3},   // R2: just above threshold
        {12'h880, 12'h800, 4'd0, 4'd11},  // R1: only enabled source wins
        {12'h012, 12'hFFE, 4'd1, 4'd1},   // R2: 1 (prio 2) beats 4 (prio 1)
        {12'h001, 12'hFFF, 4'd0, 4'd0},   // R9: source 0 ignored
        {12'hFFE, 12'h000, 4'd0, 4'd0},   // R1: nothing enabled
        {12'h00C, 12'hFFE, 4'd0, 4'd3}    // R2: higher priority beats lower ID
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_en(input int c, input logic [NS-1:0] v);
        @(negedge clk);
        en_we = 1'b1; en_ctx = 2'(c); en_val = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic set_thr(input int c, input int v);
        @(negedge clk);
        thr_we = 1'b1; thr_ctx = 2'(c); thr_val = 3'(v);
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic set_prio(input int id, input int v);
        @(negedge clk);
        prio_we = 1'b1; prio_id = 4'(id); prio_val = 3'(v);
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R8: reset state
        chk("R8 claim id after reset", int'(claim_id), 0);
        chk("R8 machine lines after reset", int'(mach_irq), 0);
        chk("R8 supervisor lines after reset", int'(sup_irq), 0);

        for (int i = 1; i < NS; i++) set_prio(i, (i % 4) + 1);

        // Table walk on context 0 (hart 0 machine line).
        for (int v = 0; v < 9; v++) begin
            @(negedge clk);
            lines = VEC[v][31:20];
            en_we = 1'b1; en_ctx = 2'd0; en_val = VEC[v][19:8];
            @(negedge clk);
            en_we = 1'b0;
            thr_we = 1'b1; thr_ctx = 2'd0; thr_val = VEC[v][6:4];
            @(negedge clk);
            thr_we = 1'b0;
            @(negedge clk);
            chk($sformatf("R2 vector %0d selected id", v), int'(claim_id), int'(VEC[v][3:0]));
            chk($sformatf("R3 vector %0d request", v), int'(mach_irq[0]), int'(VEC[v][3:0] != 0));
        end

        // R6/R3 timing on source 5 (prio 2).
        lines = '0;
        set_en(0, 12'h020);
        set_thr(0, 0);
        tick(2);
        lines[5] = 1'b1;
        tick(1);
        chk("R6 pending one cycle after line rise", int'(claim_id), 5);
        chk("R3 request not yet raised", int'(mach_irq[0]), 0);
        tick(1);
        chk("R3 request raised one cycle later", int'(mach_irq[0]), 1);

        // R4 claim with the line still high; ctx2 also enables source 5.
        set_en(2, 12'h020);
        claim_ctx = 2'd0;
        claim = 1'b1;
        chk("R4 claim returns winner", int'(claim_id), 5);
        tick(1);
        claim = 1'b0;
        chk("R4 claimed source not selectable", int'(claim_id), 0);
        tick(3);
        chk("R4 still excluded while line high", int'(claim_id), 0);
        chk("R4 ctx0 request dropped", int'(mach_irq[0]), 0);
        claim_ctx = 2'd2;
        tick(1);
        chk("R4 excluded for other context", int'(claim_id), 0);
        chk("R4 hart1 machine request low", int'(mach_irq[1]), 0);
        claim_ctx = 2'd0;

        // R5 complete out of range, then in range.
        done_id = 4'd13; done = 1'b1;
        tick(1);
        done = 1'b0;
        tick(2);
        chk("R5 out-of-range complete ignored", int'(claim_id), 0);
        done_id = 4'd5; done = 1'b1;
        tick(1);
        done = 1'b0;
        chk("R5 complete releases source", int'(claim_id), 5);

        // R6 line fall.
        lines[5] = 1'b0;
        tick(1);
        chk("R6 pending cleared after line fall", int'(claim_id), 0);
        set_en(2, 12'h000);

        // R11 empty claim, then source 5 returns.
        tick(2);
        claim = 1'b1;
        chk("R11 empty claim returns 0", int'(claim_id), 0);
        tick(1);
        claim = 1'b0;
        lines[5] = 1'b1;
        tick(1);
        chk("R11 state unchanged by empty claim", int'(claim_id), 5);

        // R7 routing: ctx1 (hart0 supervisor) and ctx3 (hart1, mode 00).
        lines = 12'h040;
        set_en(0, 12'h000);
        set_en(1, 12'h040);
        set_en(3, 12'h040);
        tick(2);
        chk("R7 hart0 supervisor line", int'(sup_irq[0]), 1);
        chk("R7 hart0 machine line", int'(mach_irq[0]), 0);
        chk("R7 hart1 machine line", int'(mach_irq[1]), 0);
        chk("R7 hart1 supervisor line", int'(sup_irq[1]), 0);
        claim_ctx = 2'd3;
        tick(1);
        chk("R7 unrouted context still selects", int'(claim_id), 6);
        claim_ctx = 2'd0;

        // R10 oversized threshold write ignored.
        set_en(1, 12'h000);
        set_en(3, 12'h000);
        set_en(0, 12'h040);
        set_thr(0, 2);
        set_thr(0, 6);
        tick(1);
        chk("R10 threshold above limit ignored", int'(claim_id), 6);

        // R9 enable bit 0 and line 0 have no effect.
        lines = 12'h001;
        set_en(0, 12'h001);
        set_thr(0, 0);
        tick(2);
        chk("R9 source 0 never selected", int'(claim_id), 0);
        chk("R9 no request from source 0", int'(mach_irq[0]), 0);

        // R8 reset mid-run clears configuration and state.
        lines = 12'h040;
        set_en(0, 12'h040);
        tick(2);
        chk("R8 pre-reset request", int'(mach_irq[0]), 1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R8 enables cleared by reset", int'(claim_id), 0);
        chk("R8 request cleared by reset", int'(mach_irq[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule